// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a small serial EEPROM with 64 words of 16 bits. A host selects it with a chip-select line and clocks a start bit, a two-bit opcode, a six-bit address and, for the writing commands, sixteen data bits into a data-in line, one bit per rising shift-clock edge. The block reads words back over a data-out line. It rewrites single words or the whole array in a self-timed programming cycle. It keeps a persistent enable flag that guards every programming command.

Chip select, shift clock and data in are sampled on a fast system clock. A shift-clock rising edge is seen at the first system clock edge that samples the shift clock high. The programming time is a parameter counted in system clocks. While that cycle runs, the host raises chip select and polls data out for a busy or ready indication. After reset the array holds a computed fill pattern and programming is disabled.

Top module: `eep_serial_slave`

## Requirements
- R1: After reset, word i holds the low 16 bits of (FILL_SEED ^ (i*257)), programming is disabled, and do_oe is low.
- R2: While cs is low, do_oe is low and do_o is 0.
- R3: After cs rises, zeros on di are skipped until a 1 start bit arrives. The next two bits are the opcode, MSB first, and the six bits after them are the address, MSB first. Opcode encodings: 10 read, 01 write, 11 erase, 00 extended.
- R4: For READ, do_o drives a dummy 0 after the last address bit. Each of the following 16 shift-clock rises presents the addressed word, MSB first. Further rises give 0.
- R5: Under opcode 00, address bits [5:4] = 11 enable programming and 00 disable it. Write, erase, erase-all and write-all frames start no programming while disabled.
- R6: WRITE takes 16 data bits, MSB first, after the address. When enabled, it replaces the word on the next fall of cs. No prior erase is needed.
- R7: ERASE sets the addressed word to 16'hFFFF.
- R8: Extended 10xxxx (erase-all) sets every word to 16'hFFFF. Extended 01xxxx (write-all) takes 16 data bits and stores them in every word.
- R9: The busy cycle starts at the system clock edge that samples cs low after a complete programming frame. It lasts exactly T_PROG clocks, and the memory is updated when it ends.
- R10: With cs raised after programming starts and no new frame begun, do_oe is 1 and do_o reads 0 while busy and 1 once ready. Start bits are ignored while busy.
- R11: A writing frame cut short by cs falling before all its data bits arrive starts no programming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Shift clock, sampled on clk |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out or ready/busy status |
| do_oe | output | 1 | Output enable for do_o |

## Verification
Every shift-clock rise takes effect at the system clock edge that first samples it high. The bench therefore reads data out at the falling clock edge after that rise, which covers the dummy bit and every read bit. Programming becomes ready exactly T_PROG clock edges after the edge that samples chip select low. The bench counts falling edges from that edge and expects the first ready reading at count T_PROG. Data out is compared at every falling clock edge while chip select is low.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    PK_NONE, PK_WRITE, PK_ERASE, PK_ERAL, PK_WRAL
  } prog_e;

  // Reset-time content of word idx.
  function automatic logic [31:0] fill_word(input int unsigned idx, input logic [31:0] seed);
    return seed ^ (idx * 32'd257);
  endfunction

  // Commands that write all ones.
  function automatic logic is_clear(input prog_e k);
    return (k == PK_ERASE) || (k == PK_ERAL);
  endfunction

  // Commands that touch every word.
  function automatic logic is_bulk(input prog_e k);
    return (k == PK_ERAL) || (k == PK_WRAL);
  endfunction
endpackage

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int T_PROG = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CTW = (T_PROG > 2) ? $clog2(T_PROG) : 1;

  logic [CTW-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CTW'(T_PROG - 1);
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int          DW        = 16,
  parameter logic [31:0] FILL_SEED = 32'h0000A5C3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_one,
  input  logic          we_all,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= DW'(fill_word(g, FILL_SEED));
      else if (we_all || (we_one && (waddr == AW'(g))))
        mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep_frame.sv
module eep_frame
  import eep_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk,
  input  logic          di,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          prog_start,
  output prog_e         kind,
  output logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] tgt_data,
  output logic          wen,
  output logic          do_o,
  output logic          do_oe
);
  localparam int HL  = 2 + AW;
  localparam int LEN = (HL > DW) ? HL : DW;
  localparam int CW  = $clog2(LEN) + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_HDR, S_DATA, S_READ, S_DONE} st_e;

  st_e           st_q;
  logic          cs_q, sk_q, wen_q, armed_q, stat_q, dbit_q;
  logic [CW-1:0] cnt_q;
  logic [HL-1:0] hdr_q;
  logic [DW-1:0] dat_q, rsh_q;
  prog_e         kind_q;
  logic [AW-1:0] addr_q;

  logic          sk_rise, cs_fall;
  logic [HL-1:0] hdr_next;
  op_e           op_w;
  logic [1:0]    ext_w;

  assign sk_rise    = cs && sk && !sk_q;
  assign cs_fall    = cs_q && !cs;
  assign hdr_next   = {hdr_q[HL-2:0], di};
  assign op_w       = op_e'(hdr_next[HL-1 -: 2]);
  assign ext_w      = hdr_next[AW-1 -: 2];
  assign rd_addr    = hdr_next[AW-1:0];
  assign prog_start = cs_fall && armed_q && wen_q;
  assign kind       = kind_q;
  assign tgt_addr   = addr_q;
  assign tgt_data   = dat_q;
  assign wen        = wen_q;
  assign do_oe      = cs && ((st_q == S_READ) || (st_q == S_START && stat_q));
  assign do_o       = do_oe && ((st_q == S_READ) ? dbit_q : !busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      wen_q   <= 1'b0;
      armed_q <= 1'b0;
      stat_q  <= 1'b0;
      dbit_q  <= 1'b0;
      cnt_q   <= '0;
      hdr_q   <= '0;
      dat_q   <= '0;
      rsh_q   <= '0;
      kind_q  <= PK_NONE;
      addr_q  <= '0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      if (!cs) begin
        st_q    <= S_IDLE;
        armed_q <= 1'b0;
        if (prog_start) stat_q <= 1'b1;
      end else if (st_q == S_IDLE) begin
        st_q <= S_START;
      end else if (sk_rise) begin
        unique case (st_q)
          S_START: if (di && !busy) begin
            st_q   <= S_HDR;
            cnt_q  <= '0;
            stat_q <= 1'b0;
          end
          S_HDR: begin
            hdr_q <= hdr_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(HL - 1)) begin
              addr_q <= hdr_next[AW-1:0];
              cnt_q  <= '0;
              st_q   <= S_DONE;
              unique case (op_w)
                OP_READ: begin
                  rsh_q  <= rd_word;
                  dbit_q <= 1'b0;
                  st_q   <= S_READ;
                end
                OP_WRITE: begin
                  kind_q <= PK_WRITE;
                  st_q   <= S_DATA;
                end
                OP_ERASE: begin
                  kind_q  <= PK_ERASE;
                  armed_q <= 1'b1;
                end
                OP_EXT: begin
                  unique case (ext_w)
                    2'b11: wen_q <= 1'b1;
                    2'b00: wen_q <= 1'b0;
                    2'b10: begin
                      kind_q  <= PK_ERAL;
                      armed_q <= 1'b1;
                    end
                    2'b01: begin
                      kind_q <= PK_WRAL;
                      st_q   <= S_DATA;
                    end
                  endcase
                end
              endcase
            end
          end
          S_DATA: begin
            dat_q <= {dat_q[DW-2:0], di};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(DW - 1)) begin
              armed_q <= 1'b1;
              st_q    <= S_DONE;
            end
          end
          S_READ: begin
            dbit_q <= rsh_q[DW-1];
            rsh_q  <= {rsh_q[DW-2:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave
  import eep_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int          DW        = 16,
  parameter int          T_PROG    = 200,
  parameter logic [31:0] FILL_SEED = 32'h0000A5C3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  logic          busy, done, prog_start, wen;
  prog_e         kind;
  logic [AW-1:0] tgt_addr, rd_addr;
  logic [DW-1:0] tgt_data, rd_word, wval;
  logic          we_one, we_all;

  eep_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .busy(busy),
    .rd_word(rd_word), .rd_addr(rd_addr), .prog_start(prog_start),
    .kind(kind), .tgt_addr(tgt_addr), .tgt_data(tgt_data), .wen(wen),
    .do_o(do_o), .do_oe(do_oe)
  );

  eep_prog_timer #(.T_PROG(T_PROG)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(done)
  );

  assign we_all = done && is_bulk(kind);
  assign we_one = done && !is_bulk(kind) && (kind != PK_NONE);
  assign wval   = is_clear(kind) ? {DW{1'b1}} : tgt_data;

  eep_array #(.AW(AW), .DW(DW), .FILL_SEED(FILL_SEED)) u_array (
    .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
    .waddr(tgt_addr), .wdata(wval), .raddr(rd_addr), .rdata(rd_word)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int T_PROG = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_o,
  input logic do_oe,
  input logic busy,
  input logic done,
  input logic prog_start,
  input logic wen
);
  int unsigned bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_oe); // R2
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == T_PROG)); // R9
  AST_COMMIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy); // R10
  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe && busy) |-> !do_o); // R10
  AST_ENABLED_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wen); // R5
endmodule

bind eep_serial_slave eep_checker #(.T_PROG(T_PROG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_o(do_o), .do_oe(do_oe),
  .busy(busy), .done(done), .prog_start(prog_start), .wen(wen)
);

// File: tb/sim_eep_serial_slave.sv
`timescale 1ns/1ps
module sim_eep_serial_slave;
  localparam int TP = 60;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int n_chk = 0, n_fail = 0;
  logic [15:0] mdl [64];
  bit finished = 0;

  always #5 clk = ~clk;

  eep_serial_slave #(.T_PROG(TP)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: per-clock comparison while deselected
  always @(negedge clk) begin
    #1;
    if (rst_n && !cs && !finished) chk(!do_oe && !do_o, "R2 quiet when deselected", {do_oe, do_o}, 0);
  end

  task automatic pulse(input logic b, output logic so, output logic soe);
    di = b;
    @(negedge clk); sk = 1'b1;
    @(negedge clk); #1; so = do_o; soe = do_oe; sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1; repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] op, input logic [5:0] a, input int ndata,
                            input logic [15:0] d, input int lead);
    logic so, soe;
    cs_on();
    for (int i = 0; i < lead; i++) pulse(1'b0, so, soe);
    pulse(1'b1, so, soe);
    for (int i = 1; i >= 0; i--) pulse(op[i], so, soe);
    for (int i = 5; i >= 0; i--) pulse(a[i], so, soe);
    for (int i = 0; i < ndata; i++) pulse(d[15-i], so, soe);
  endtask

  task automatic do_read(input logic [5:0] a, input int lead, input string tag);
    logic so, soe;
    logic [15:0] w;
    cs_on();
    for (int i = 0; i < lead; i++) pulse(1'b0, so, soe);
    pulse(1'b1, so, soe);
    pulse(1'b1, so, soe);
    pulse(1'b0, so, soe);
    for (int i = 5; i >= 0; i--) pulse(a[i], so, soe);
    chk(soe && !so, "R4 dummy zero", {soe, so}, 2'b10);
    for (int i = 15; i >= 0; i--) begin
      pulse(1'b0, so, soe);
      w[i] = so;
    end
    chk(w == mdl[a], tag, w, mdl[a]);
    pulse(1'b0, so, soe);
    chk(soe && !so, "R4 zero after word", {soe, so}, 2'b10);
    cs_off();
  endtask

  // kind: 0 write, 1 erase, 2 erase-all, 3 write-all
  task automatic prog_poll(input bit go, input int kind, input logic [5:0] a,
                           input logic [15:0] d, input string tag);
    int k;
    bit got;
    @(negedge clk); cs = 1'b0;
    @(negedge clk); cs = 1'b1;
    if (go) begin
      k = 0; got = 0;
      while (!got && k < TP + 20) begin
        @(negedge clk); #1; k++;
        if (k == 1) chk(do_oe && !do_o, "R10 busy status", {do_oe, do_o}, 2'b10);
        if (do_oe && do_o) got = 1;
      end
      chk(k == TP, "R9 busy length", k, TP);
      for (int i = 0; i < 64; i++)
        if (kind >= 2 || i == a) mdl[i] = (kind == 1 || kind == 2) ? 16'hFFFF : d;
    end else begin
      @(negedge clk); #1;
      chk(!do_oe, tag, do_oe, 0);
    end
    cs_off();
  endtask

  initial begin
    logic so, soe;
    int k;
    for (int i = 0; i < 64; i++) mdl[i] = 16'(32'h0000A5C3 ^ (i * 257));
    repeat (3) @(negedge clk);
    #1; chk(!do_oe, "R1 reset output enable", do_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(6'd0, 0, "R1 fill word 0");
    do_read(6'd5, 0, "R1 fill word 5");
    do_read(6'd63, 0, "R4 read last word");
    do_read(6'd17, 3, "R3 leading zeros skipped");
    // R5: disabled at power-up
    send_frame(2'b01, 6'd5, 16, 16'h1234, 0);
    prog_poll(0, 0, 6'd5, 16'h1234, "R5 write ignored when disabled");
    do_read(6'd5, 0, "R5 word unchanged");
    // R5 enable, R6 write
    send_frame(2'b00, 6'b110000, 0, 16'h0, 0); cs_off();
    send_frame(2'b01, 6'd5, 16, 16'hBEEF, 0);
    prog_poll(1, 0, 6'd5, 16'hBEEF, "R6");
    do_read(6'd5, 0, "R6 write result");
    send_frame(2'b01, 6'd5, 16, 16'h0F0F, 0);
    prog_poll(1, 0, 6'd5, 16'h0F0F, "R6");
    do_read(6'd5, 0, "R6 overwrite without erase");
    do_read(6'd4, 0, "R6 neighbour untouched");
    // R7 erase
    send_frame(2'b11, 6'd7, 0, 16'h0, 0);
    prog_poll(1, 1, 6'd7, 16'h0, "R7");
    do_read(6'd7, 0, "R7 erase result");
    // R11 incomplete write
    send_frame(2'b01, 6'd9, 8, 16'h3C3C, 0);
    prog_poll(0, 0, 6'd9, 16'h0, "R11 short frame no programming");
    do_read(6'd9, 0, "R11 word unchanged");
    // R8 write-all, erase-all
    send_frame(2'b00, 6'b010000, 16, 16'h5A5A, 0);
    prog_poll(1, 3, 6'd0, 16'h5A5A, "R8");
    do_read(6'd0, 0, "R8 write-all word 0");
    do_read(6'd33, 0, "R8 write-all word 33");
    send_frame(2'b00, 6'b100000, 0, 16'h0, 0);
    prog_poll(1, 2, 6'd0, 16'h0, "R8");
    do_read(6'd62, 0, "R8 erase-all word 62");
    // R10 start bits ignored while busy: disable frame sent during busy
    send_frame(2'b01, 6'd2, 16, 16'h1111, 0);
    @(negedge clk); cs = 1'b0;
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
    pulse(1'b1, so, soe);
    chk(soe && !so, "R10 busy during poll", {soe, so}, 2'b10);
    for (int i = 0; i < 8; i++) pulse(1'b0, so, soe);
    k = 0;
    while (!(do_oe && do_o) && k < TP + 20) begin @(negedge clk); #1; k++; end
    chk(do_oe && do_o, "R10 ready reported", {do_oe, do_o}, 2'b11);
    mdl[2] = 16'h1111;
    cs_off();
    send_frame(2'b01, 6'd3, 16, 16'h2222, 0);
    prog_poll(1, 0, 6'd3, 16'h2222, "R10");
    do_read(6'd3, 0, "R10 enable kept after ignored frame");
    do_read(6'd2, 0, "R10 busy write landed");
    // R5 disable
    send_frame(2'b00, 6'b001111, 0, 16'h0, 0); cs_off();
    send_frame(2'b11, 6'd4, 0, 16'h0, 0);
    prog_poll(0, 1, 6'd4, 16'h0, "R5 erase ignored after disable");
    do_read(6'd4, 0, "R5 word kept after disable");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    finished = 1;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule